// File: doc/BRIEF.md
# Table-Driven Four-Bit Sequencer

The block is a small finite state machine in which a four-bit state register takes a new value from a constant lookup table on every clock edge. The table is indexed by the current state together with a two-bit mode input. The selected entry is the next state. No adder or incrementer sits in the feedback path. Every transition, including a wrap or a jump, comes from the table contents.

The table holds four behaviours, one for each mode code:
- holding the present value,
- stepping down by one,
- a full-period pseudo-random walk of the form (5·s + 3) mod 16,
- stepping up by one.

Because the mode is part of the address, it can change on any cycle and takes effect on the next edge. The reset input is asynchronous and active low. Its release passes through a short synchronizer before the register starts loading.

Top module: `lut_sequencer`

## Requirements
- R1: On every clock edge outside reset, the state loads the table entry addressed by {mode, state}, with mode in the upper two address bits and state in the lower four.
- R2: While rst_n is low, the state is 0, and it clears without waiting for a clock edge. After rst_n rises, the state stays 0 for two further rising edges and first loads from the table on the third.
- R3: Mode code 2'b00 keeps the state unchanged.
- R4: Mode code 2'b01 gives next = (state − 1) mod 16, so 0 goes to 15.
- R5: Mode code 2'b10 gives next = (5·state + 3) mod 16. Starting from 0, it visits all 16 values before returning to 0 after exactly 16 edges.
- R6: Mode code 2'b11 gives next = (state + 1) mod 16, so 15 goes to 0.
- R7: A change of mode applies on the very next edge, so a different mode on each successive cycle yields the chained composition of the per-mode rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Behaviour select, upper part of the table address |
| state | output | 4 | Current state register value |

## Verification
The bench builds the block with its default parameters: a four-bit state, a two-bit mode, multiplier 5, increment 3 and a two-stage reset synchronizer. With these values the whole 64-entry table can be covered. Every one of the 16 states is reached through the up-count mode, and then a single edge is taken in each of the four modes, with the expected value computed arithmetically. Further checks cover the full period of the pseudo-random walk, a per-cycle mode-switching chain, and the exact edge count between the rise of rst_n and the first load. A reset applied between clock edges is also checked.

// File: rtl/lut_seq_pkg.sv
package lut_seq_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_LCG  = 2'b10,
    MODE_UP   = 2'b11
  } seq_mode_e;

  // Next-state value for one table slot; the caller truncates to the state width.
  function automatic int unsigned slot_value(input int unsigned sel,
                                             input int unsigned cur,
                                             input int unsigned mul,
                                             input int unsigned add,
                                             input int unsigned modulus);
    int unsigned r;
    case (sel)
      0:       r = cur;
      1:       r = (cur + modulus - 1) % modulus;
      2:       r = (mul * cur + add) % modulus;
      default: r = (cur + 1) % modulus;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lut_seq_rst_sync.sv
module lut_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign run_n = chain_q[STAGES-1];

  // R2: the released reset rises only after the raw reset has been high
  a_r2_release_after_input: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(run_n) |-> $past(arst_n));

endmodule

// File: rtl/lut_seq_table.sv
module lut_seq_table
  import lut_seq_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned LCG_MUL = 5,
  parameter int unsigned LCG_ADD = 3
) (
  input  logic [MODE_W+STATE_W-1:0] addr,
  output logic [STATE_W-1:0]        data
);

  localparam int unsigned ADDR_W  = MODE_W + STATE_W;
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned MODULUS = 1 << STATE_W;

  logic [STATE_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int unsigned SEL = i / MODULUS;
    localparam int unsigned CUR = i % MODULUS;
    localparam int unsigned VAL = slot_value(SEL, CUR, LCG_MUL, LCG_ADD, MODULUS);
    assign rom[i] = STATE_W'(VAL);
  end

  assign data = rom[addr];

endmodule

// File: rtl/lut_seq_state_reg.sv
module lut_seq_state_reg #(
  parameter int unsigned STATE_W = 4
) (
  input  logic               clk,
  input  logic               run_n,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_val,
  output logic [STATE_W-1:0] q
);

  logic [STATE_W-1:0] q_r;
  logic [STATE_W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (load_en) q_d = load_val;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  // R2: a cycle spent in reset leaves the register cleared
  a_r2_cleared_in_reset: assert property (@(posedge clk)
    !run_n |=> (q_r == '0));

endmodule

// File: rtl/lut_sequencer.sv
module lut_sequencer
  import lut_seq_pkg::*;
#(
  parameter int unsigned STATE_W     = 4,
  parameter int unsigned MODE_W      = 2,
  parameter int unsigned LCG_MUL     = 5,
  parameter int unsigned LCG_ADD     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode,
  output logic [STATE_W-1:0] state
);

  localparam int unsigned ADDR_W = MODE_W + STATE_W;

  logic               run_n;
  logic [ADDR_W-1:0]  rom_addr;
  logic [STATE_W-1:0] rom_data;
  logic               load_en;

  lut_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .run_n  (run_n)
  );

  assign rom_addr = {mode, state};

  lut_seq_table #(
    .STATE_W (STATE_W),
    .MODE_W  (MODE_W),
    .LCG_MUL (LCG_MUL),
    .LCG_ADD (LCG_ADD)
  ) u_table (
    .addr (rom_addr),
    .data (rom_data)
  );

  // Parallel load is enabled permanently: the table is the only next-state source.
  assign load_en = 1'b1;

  lut_seq_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk      (clk),
    .run_n    (run_n),
    .load_en  (load_en),
    .load_val (rom_data),
    .q        (state)
  );

  // R3: hold keeps the state
  a_r3_hold: assert property (@(posedge clk) disable iff (!run_n)
    (mode == MODE_HOLD) |=> (state == $past(state)));

  // R4: down-count with wrap
  a_r4_down: assert property (@(posedge clk) disable iff (!run_n)
    (mode == MODE_DOWN) |=> (state == STATE_W'($past(state) - 1'b1)));

  // R5: linear congruential step
  a_r5_lcg: assert property (@(posedge clk) disable iff (!run_n)
    (mode == MODE_LCG) |=> (state == STATE_W'($past(state) * LCG_MUL + LCG_ADD)));

  // R6: up-count with wrap
  a_r6_up: assert property (@(posedge clk) disable iff (!run_n)
    (mode == MODE_UP) |=> (state == STATE_W'($past(state) + 1'b1)));

  // R1: the register follows the table output from the previous cycle
  a_r1_loads_table: assert property (@(posedge clk) disable iff (!run_n)
    1'b1 |=> (state == $past(rom_data)));

endmodule

// File: tb/lut_sequencer_tb.sv
module lut_sequencer_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  lut_sequencer u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .state (state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model(input int m, input int s);
    case (m)
      0:       return 4'(s);
      1:       return 4'(s + 15);
      2:       return 4'(5 * s + 3);
      default: return 4'(s + 1);
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0:       return "R3";
      1:       return "R4";
      2:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (state !== exp) begin
      errors++;
      $display("FAIL %s: state=%0d expected=%0d at %0t", req, state, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_to(input int target);
    mode = 2'b11;
    for (int k = 0; k < 17 && state !== 4'(target); k++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [3:0] exp_s;
    logic [15:0] seen;
    int chain [7] = '{3, 3, 1, 2, 0, 2, 1};

    // R2: reset state, then two edges of delay after release
    repeat (3) step();
    check("R2", 4'd0);
    rst_n = 1'b1;
    step();
    check("R2", 4'd0);
    step();
    check("R2", 4'd0);
    step();
    check("R1", 4'd1);

    // R3 R4 R5 R6: every table slot, one edge each
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        go_to(s);
        check("R1", 4'(s));
        mode = 2'(m);
        step();
        check(tag_of(m), model(m, s));
      end
    end

    // R5: full period from zero
    go_to(0);
    mode = 2'b10;
    seen = '0;
    for (int k = 0; k < 16; k++) begin
      seen[state] = 1'b1;
      step();
    end
    checks++;
    if (seen !== 16'hFFFF) begin
      errors++;
      $display("FAIL R5: visited=%h expected=%h", seen, 16'hFFFF);
    end
    check("R5", 4'd0);

    // R7: a new mode on each cycle
    go_to(7);
    exp_s = 4'd7;
    for (int k = 0; k < 7; k++) begin
      mode = 2'(chain[k]);
      step();
      exp_s = model(chain[k], exp_s);
      check("R7", exp_s);
    end

    // R2: reset asserted between edges clears without a clock
    go_to(9);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R2", 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mode = 2'b10;
    step();
    check("R2", 4'd0);
    step();
    check("R2", 4'd0);
    step();
    check("R5", 4'd3);

    finish_run();
  end

endmodule